// File: doc/BRIEF.md
# Differential Delay-Line ADC Back End

This block is the digital side of a voltage ADC that works by comparing two delay chains. It runs one conversion at a time. First it clears both external chains. Then it launches a single edge into both chains together. It waits for the reference chain to finish, and that moment samples every tap of the primary chain. The primary chain is powered from the lower sense voltage, so at that instant its edge has covered only part of the chain.

The sampled taps form a thermometer code. The block brings that code into the system clock domain and counts the taps the edge has not yet reached. It reports the count as a saturating error word, together with a one-cycle strobe. The word is zero when the two voltages match and grows as the sense voltage falls. A controller above the block requests conversions at its own rate, for example once per switching period.

If the reference chain never finishes, the block abandons the conversion after a bounded wait. It then flags the fault and leaves the last good word in place.

Top module: `dline_adc_backend`

## Requirements
- R1: A `conv_go` pulse accepted in the idle state drives `chain_clr` high for exactly CLR_CYCLES consecutive clock cycles (default 4). `chain_start` stays low during that time.
- R2: `chain_start` rises in the cycle after `chain_clr` falls, is held until the tap sample has been taken, and is low again when `err_valid` is reported.
- R3: The primary taps are sampled on the rising edge of `ref_done`. Taps that rise after that edge have no effect on the word reported.
- R4: The error word equals N_TAPS minus the number of ones in the sampled taps. Bit k of `prim_taps` is tap k+1 of the primary chain.
- R5: The error word saturates at 2^ERR_W-1 (63 with ERR_W=6) when more taps are missing than that value can hold.
- R6: When every primary tap is reached before the reference finishes, the word is 0.
- R7: The decoder counts ones, so a thermometer code with one hole inside the run reports one more than the same run without the hole.
- R8: Every completed conversion produces exactly one `err_valid` pulse, one clock cycle wide.
- R9: `err_word` changes only in a cycle where `err_valid` is high, and holds its value otherwise, including across a timed-out conversion.
- R10: If `ref_done` is not seen within TIMEOUT_CYC cycles of the launch, the sequence returns to idle without an `err_valid`. `ref_timeout` is then raised and stays high until the next `conv_go` is accepted.
- R11: A `conv_go` that arrives while a conversion is in progress is ignored. It starts no second clear and produces no second word.
- R12: After reset, `chain_clr`, `chain_start`, `err_valid` and `ref_timeout` are low and `err_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_go | input | 1 | Request one conversion (sampled in idle only) |
| ref_done | input | 1 | Asynchronous last tap of the reference chain |
| prim_taps | input | N_TAPS | Asynchronous taps of the primary chain, bit 0 nearest the launch |
| chain_clr | output | 1 | Clear both delay chains |
| chain_start | output | 1 | Shared launch edge into both chains |
| err_word | output | ERR_W | Saturated count of unreached primary taps |
| err_valid | output | 1 | One-cycle strobe for a new `err_word` |
| ref_timeout | output | 1 | Reference chain failed to finish in time |

## Verification
On every cycle, the assertions check the ordering of the sequence: clear and launch are never high together, a launch always follows a clear, a clear only leaves idle, and a timeout only leaves the wait state. They also check the output contract: the strobe is a single cycle wide and the word moves only with it. The numeric mapping from thermometer code to error word needs analog-like stimulus, so only the bench's scenarios can show it. That covers the voltage-dependent tap timing, taps that keep rising after the sample, bubbles, and saturation on a 72-tap instance. The same holds for the exact clear length, the ignored mid-conversion requests and the clearing of the timeout flag.

// File: rtl/dline_pkg.sv
// Package: shared sequencer state encoding for the delay-line ADC back end.
// Assumes: nothing beyond IEEE 1800-2017.
package dline_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CLR    = 3'd1,
        ST_LAUNCH = 3'd2,
        ST_WAIT   = 3'd3,
        ST_SETTLE = 3'd4,
        ST_EMIT   = 3'd5
    } seq_state_t;

endpackage

// File: rtl/dline_seq.sv
// Module: conversion sequencer. Walks idle -> clear -> launch -> wait for the
// reference -> settle -> emit, with a bounded wait that flags a timeout.
// Assumes: ref_seen is already synchronous to clk; CLR_CYCLES is at least the
// synchronizer depth + 1, so a stale reference flag is flushed before waiting.
module dline_seq
    import dline_pkg::*;
#(
    parameter int CLR_CYCLES  = 4,
    parameter int TIMEOUT_CYC = 32,
    parameter int SETTLE_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_go,
    input  logic ref_seen,
    output logic chain_clr,
    output logic chain_start,
    output logic load_word,
    output logic ref_timeout
);

    localparam int MAX_CNT = (CLR_CYCLES > TIMEOUT_CYC) ?
                             ((CLR_CYCLES > SETTLE_CYC) ? CLR_CYCLES : SETTLE_CYC) :
                             ((TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC);
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tmo_q;

    // State, phase counter and timeout flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tmo_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (conv_go) begin
                        state_q <= ST_CLR;
                        tmo_q   <= 1'b0;
                    end
                end
                ST_CLR: begin
                    if (cnt_q == CNT_W'(CLR_CYCLES - 1)) begin
                        state_q <= ST_LAUNCH;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_LAUNCH: begin
                    state_q <= ST_WAIT;
                    cnt_q   <= '0;
                end
                ST_WAIT: begin
                    if (ref_seen) begin
                        state_q <= ST_SETTLE;
                        cnt_q   <= '0;
                    end else if (cnt_q == CNT_W'(TIMEOUT_CYC - 1)) begin
                        state_q <= ST_IDLE;
                        tmo_q   <= 1'b1;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (cnt_q == CNT_W'(SETTLE_CYC - 1)) begin
                        state_q <= ST_EMIT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_EMIT: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Chain controls and load strobe decoded from the registered state.
    always_comb begin
        chain_clr   = (state_q == ST_CLR);
        chain_start = (state_q == ST_LAUNCH) || (state_q == ST_WAIT) ||
                      (state_q == ST_SETTLE);
        load_word   = (state_q == ST_EMIT);
        ref_timeout = tmo_q;
    end

    a_r1_clr_start_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(chain_clr && chain_start));

    a_r2_start_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_start) |-> $past(chain_clr));

    a_r11_clr_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_clr) |-> $past(state_q == ST_IDLE));

    a_r10_timeout_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_timeout) |-> $past(state_q == ST_WAIT));

endmodule

// File: rtl/dline_capture.sv
// Module: samples the primary taps on the reference-done edge, then carries
// the sample and the reference flag into the clk domain through flop chains.
// Assumes: taps are stable around the ref_done edge (they only rise), and
// the sample is not re-captured until the next conversion's clear.
module dline_capture #(
    parameter int N_TAPS      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_done,
    input  logic [N_TAPS-1:0] prim_taps,
    output logic [N_TAPS-1:0] taps_sync,
    output logic              ref_seen
);

    logic [N_TAPS-1:0]      cap_q;
    logic [N_TAPS-1:0]      stage_q [SYNC_STAGES];
    logic [SYNC_STAGES-1:0] ref_q;

    // Freeze the primary chain at the instant the reference chain completes.
    always_ff @(posedge ref_done) begin
        cap_q <= prim_taps;
    end

    // Carry the frozen code and the completion flag into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
            ref_q <= '0;
        end else begin
            stage_q[0] <= cap_q;
            for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
            ref_q <= {ref_q[SYNC_STAGES-2:0], ref_done};
        end
    end

    assign taps_sync = stage_q[SYNC_STAGES-1];
    assign ref_seen  = ref_q[SYNC_STAGES-1];

endmodule

// File: rtl/dline_decode.sv
// Module: counts ones in the synchronized thermometer code, converts it to
// the number of unreached taps, saturates, and registers word plus strobe.
// Assumes: load is a single-cycle pulse from the sequencer.
module dline_decode #(
    parameter int N_TAPS = 16,
    parameter int ERR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [N_TAPS-1:0] taps,
    output logic [ERR_W-1:0]  err_word,
    output logic              err_valid
);

    localparam int CW   = $clog2(N_TAPS + 1);
    localparam int MAXV = (1 << ERR_W) - 1;

    logic [CW-1:0]    ones;
    logic [CW-1:0]    miss;
    logic [ERR_W-1:0] sat;

    // Population count, then distance to full chain, then clamp.
    always_comb begin
        ones = '0;
        for (int i = 0; i < N_TAPS; i++) ones = ones + CW'(taps[i]);
        miss = CW'(N_TAPS) - ones;
        if (32'(miss) > MAXV) sat = ERR_W'(MAXV);
        else                  sat = ERR_W'(miss);
    end

    // Output word register and one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_word  <= '0;
            err_valid <= 1'b0;
        end else begin
            err_valid <= load;
            if (load) err_word <= sat;
        end
    end

    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);

    a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_word) |-> err_valid);

endmodule

// File: rtl/dline_adc_backend.sv
// Module: top of the delay-line ADC back end. Connects the sequencer, the
// tap capture/synchronizer and the thermometer decoder.
// Assumes: external chains clear while chain_clr is high and propagate a
// rising edge while chain_start is high; ref_done is the reference last tap.
module dline_adc_backend #(
    parameter int N_TAPS      = 16,
    parameter int ERR_W       = 6,
    parameter int CLR_CYCLES  = 4,
    parameter int TIMEOUT_CYC = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_go,
    input  logic              ref_done,
    input  logic [N_TAPS-1:0] prim_taps,
    output logic              chain_clr,
    output logic              chain_start,
    output logic [ERR_W-1:0]  err_word,
    output logic              err_valid,
    output logic              ref_timeout
);

    logic [N_TAPS-1:0] taps_sync;
    logic              ref_seen;
    logic              load_word;

    dline_seq #(
        .CLR_CYCLES (CLR_CYCLES),
        .TIMEOUT_CYC(TIMEOUT_CYC),
        .SETTLE_CYC (SYNC_STAGES)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_go    (conv_go),
        .ref_seen   (ref_seen),
        .chain_clr  (chain_clr),
        .chain_start(chain_start),
        .load_word  (load_word),
        .ref_timeout(ref_timeout)
    );

    dline_capture #(
        .N_TAPS     (N_TAPS),
        .SYNC_STAGES(SYNC_STAGES)
    ) cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_done (ref_done),
        .prim_taps(prim_taps),
        .taps_sync(taps_sync),
        .ref_seen (ref_seen)
    );

    dline_decode #(
        .N_TAPS(N_TAPS),
        .ERR_W (ERR_W)
    ) dec_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_word),
        .taps     (taps_sync),
        .err_word (err_word),
        .err_valid(err_valid)
    );

    a_r8_no_valid_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> !chain_start);

endmodule

// File: tb/dline_adc_backend_tb_top.sv
`timescale 1ps/1ps
module dline_adc_backend_tb_top;

    localparam int N    = 16;
    localparam int NW   = 72;
    localparam int HALF = 2500;
    localparam int TREF = 32000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic          conv_go = 1'b0, ref_done = 1'b0;
    logic [N-1:0]  prim_taps = '0;
    logic          chain_clr, chain_start, err_valid, ref_timeout;
    logic [5:0]    err_word;

    logic          go_w = 1'b0, ref_w = 1'b0;
    logic [NW-1:0] taps_w = '0;
    logic          clr_w, start_w, valid_w, tmo_w;
    logic [5:0]    word_w;

    int n_chk = 0;
    int n_bad = 0;

    always #HALF clk = ~clk;

    dline_adc_backend #(.N_TAPS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .conv_go(conv_go), .ref_done(ref_done),
        .prim_taps(prim_taps), .chain_clr(chain_clr), .chain_start(chain_start),
        .err_word(err_word), .err_valid(err_valid), .ref_timeout(ref_timeout)
    );

    dline_adc_backend #(.N_TAPS(NW)) dut_wide_i (
        .clk(clk), .rst_n(rst_n), .conv_go(go_w), .ref_done(ref_w),
        .prim_taps(taps_w), .chain_clr(clr_w), .chain_start(start_w),
        .err_word(word_w), .err_valid(valid_w), .ref_timeout(tmo_w)
    );

    // Behavioural chain clear: cells reset while the clear is asserted.
    always @(negedge clk) begin
        if (chain_clr) begin prim_taps = '0; ref_done = 1'b0; end
        if (clr_w)     begin taps_w = '0;    ref_w = 1'b0;    end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One conversion on the 16-tap instance; r = taps reached, or a fixed pattern.
    task automatic run_narrow(input int r, input bit use_pat, input logic [N-1:0] pat,
                              input int exp);
        @(negedge clk) conv_go = 1'b1;
        @(negedge clk) conv_go = 1'b0;
        fork
            begin
                @(posedge chain_start);
                fork
                    begin #(TREF) ref_done = 1'b1; end
                    begin
                        if (use_pat) begin
                            #(TREF/2) prim_taps = pat;
                        end else begin
                            int dp = (2*TREF) / (2*r + 1);
                            for (int k = 0; k < N; k++) begin #(dp) prim_taps[k] = 1'b1; end
                        end
                    end
                join
            end
            begin
                int clr_n = 0;
                int guard = 0;
                bit quiet = 1'b1;
                while (!chain_clr) @(negedge clk);
                check(ref_timeout == 1'b0, "R10 flag cleared", ref_timeout, 0);
                while (chain_clr) begin
                    clr_n++;
                    if (clr_n == 2) conv_go = 1'b1;
                    if (clr_n == 3) conv_go = 1'b0;
                    @(negedge clk);
                end
                check(clr_n == 4, "R1 clear length", clr_n, 4);
                check(chain_start == 1'b1, "R2 launch after clear", chain_start, 1);
                while (!err_valid && guard < 300) begin guard++; @(negedge clk); end
                check(err_valid == 1'b1, "R8 word produced", err_valid, 1);
                check(err_word == exp, "R4 R3 R6 R7 error word", err_word, exp);
                check(chain_start == 1'b0, "R2 launch dropped", chain_start, 0);
                @(negedge clk);
                check(err_valid == 1'b0, "R8 strobe width", err_valid, 0);
                repeat (8) begin
                    @(negedge clk);
                    if (chain_clr || err_valid) quiet = 1'b0;
                end
                check(quiet, "R11 request ignored", quiet, 1);
            end
        join
    endtask

    // One conversion on the 72-tap instance with c leading ones.
    task automatic run_wide(input int c, input int exp);
        int guard = 0;
        @(negedge clk) go_w = 1'b1;
        @(negedge clk) go_w = 1'b0;
        @(posedge start_w);
        #(TREF/2);
        for (int k = 0; k < NW; k++) taps_w[k] = (k < c);
        #(TREF/2) ref_w = 1'b1;
        @(negedge clk);
        while (!valid_w && guard < 300) begin guard++; @(negedge clk); end
        check(word_w == exp, "R5 saturation", word_w, exp);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(2*HALF*100000);
        check(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [5:0] prev;
        int guard;
        bit seen_v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(chain_clr == 0 && chain_start == 0, "R12 controls low", chain_clr, 0);
        check(err_valid == 0 && ref_timeout == 0, "R12 flags low", err_valid, 0);
        check(err_word == 0, "R12 word zero", err_word, 0);

        // R4 R3 R6: sweep every reached-tap count
        for (int r = 0; r <= N; r++) run_narrow(r, 1'b0, '0, N - r);

        // R7: single bubbles in the run
        run_narrow(0, 1'b1, 16'b0000_0000_1111_1011, 9);
        run_narrow(0, 1'b1, 16'b1111_1111_1111_1110, 1);

        // R10 R9: no reference completion
        prev = err_word;
        seen_v = 1'b0;
        guard = 0;
        @(negedge clk) conv_go = 1'b1;
        @(negedge clk) conv_go = 1'b0;
        while (!ref_timeout && guard < 100) begin
            if (err_valid) seen_v = 1'b1;
            guard++;
            @(negedge clk);
        end
        check(ref_timeout == 1'b1, "R10 timeout raised", ref_timeout, 1);
        check(!seen_v, "R10 no strobe", seen_v, 0);
        check(err_word == prev, "R9 word held", err_word, prev);
        check(chain_start == 1'b0, "R10 back to idle", chain_start, 0);
        repeat (5) @(negedge clk);
        check(ref_timeout == 1'b1, "R10 flag held", ref_timeout, 1);

        // R10: next conversion clears the flag and works
        run_narrow(10, 1'b0, '0, 6);

        // R5: saturation on the wide instance
        run_wide(0, 63);
        run_wide(9, 63);
        run_wide(10, 62);
        run_wide(40, 32);
        run_wide(NW, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule